// File: doc/BRIEF.md
# Serial Two-of-Five Postal Bar Code Digit Decoder

This block receives a postal bar code one bar at a time and turns it into binary-coded decimal digits. Every digit is sent as five bars, and exactly two of those bars are tall (logic 1). The five positions carry the weights 7, 4, 2, 1 and 0, and a digit is the sum of the weights of its two tall bars. The one exception is zero: the 7 + 4 pair would add up to eleven, so that pattern stands for zero instead. Only ten of the 32 possible five-bar words are legal. Each of the other 22 is decoded to 0000 and marks its frame as faulty.

Bars arrive on `bar_in_i`, and the block takes one whenever `bar_valid_i` is high on a rising clock edge. After every fifth bar the block decodes the word it has just completed. A frame holds a fixed number of digits, five by default, which gives the 25 bars of a zip code. After the last bar of a frame, the block loads all the decoded digits and the frame's error flag into its output registers and raises `done_o` for one cycle. The bar counters return to zero so that the next frame can begin on the very next cycle.

Top module: `zip_bar_decoder`

## Requirements
- R1: The legal five-bar words, written first bar to last, decode to these digits: 11000 to 0, 00011 to 1, 00101 to 2, 00110 to 3, 01001 to 4, 01010 to 5, 01100 to 6, 10001 to 7, 10010 to 8 and 10100 to 9.
- R2: Any of the 22 other five-bar words, whether it has zero, one, three, four or five tall bars, puts 0000 in its digit position and makes `frame_error_o` read 1 for its frame.
- R3: The first bar of a word is its most significant bit. The first digit of a frame appears on `digits_o[4*DIGITS-1 -: 4]`, and each later digit occupies the next lower nibble.
- R4: `done_o` is high for exactly one cycle, in the cycle right after the edge that takes in the last bar of a frame.
- R5: `digits_o` and `frame_error_o` change only when `done_o` rises. Between frames they hold the values of the last completed frame.
- R6: `frame_error_o` reports whether the most recent frame had an illegal word in any position. An error in one frame does not carry over into the next frame.
- R7: While `bar_valid_i` is low, `bar_in_i` is ignored and no state changes: a frame interrupted by idle cycles decodes the same as a frame sent without gaps.
- R8: Asserting `rst_n` low clears the bar and digit counters, the partial word, the stored digits, `frame_error_o` and `done_o`, even partway through a frame.
- R9: After the last bar of a frame, a bar taken on the very next edge is the first bar of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| bar_valid_i | input | 1 | Qualifies `bar_in_i` on this edge |
| bar_in_i | input | 1 | Bar value: 1 for a tall bar, 0 for a short bar |
| digits_o | output | 4*DIGITS | Decoded digits of the last frame, first digit in the top nibble |
| done_o | output | 1 | One-cycle pulse when a frame has been decoded |
| frame_error_o | output | 1 | The last frame contained at least one illegal word |

## Verification
The assertions assume that `bar_valid_i` is a clean level sampled on each rising edge and that every reset pulse spans at least one clock edge. With those assumptions, the checker can count accepted bars and require exactly one frame's worth between done pulses, and it can tie every output change to a done pulse. The bench drives inputs only on falling edges and holds reset low for at least two edges, mid-frame resets included, so it stays inside those assumptions. The bench also exercises the states the assertions depend on: idle gaps inside a frame, frames sent back to back, and a reset that cuts a frame short.

// File: rtl/zbd_pkg.sv
`timescale 1ns/1ps
package zbd_pkg;
  // Bars per code word and bits per decoded digit.
  localparam int CODE_W  = 5;
  localparam int DIGIT_W = 4;

  typedef logic [CODE_W-1:0]  code_t;
  typedef logic [DIGIT_W-1:0] digit_t;

  // Selects how the word decoder is built.
  typedef enum logic {
    DEC_SOP    = 1'b0,  // two-level equations, gated by an exact legality check
    DEC_WEIGHT = 1'b1   // explicit weighted sum with the zero exception
  } dec_style_e;

  // The pattern that stands for zero (weights 7 and 4 set).
  localparam code_t ZERO_CODE = 5'b11000;
endpackage

// File: rtl/zbd_word_decoder.sv
`timescale 1ns/1ps
module zbd_word_decoder #(
  parameter zbd_pkg::dec_style_e DEC_STYLE = zbd_pkg::DEC_SOP
) (
  input  zbd_pkg::code_t  code_i,
  output zbd_pkg::digit_t digit_o,
  output logic            bad_o
);
  import zbd_pkg::*;

  logic   two_hot;
  digit_t raw;

  // Exact legality: any word without exactly two tall bars is rejected.
  assign two_hot = ($countones(code_i) == 2);
  assign bad_o   = ~two_hot;

  generate
    if (DEC_STYLE == DEC_SOP) begin : g_sop
      logic v, w, x, y, z;
      assign {v, w, x, y, z} = code_i;
      always_comb begin
        raw[3] = v & (x | y);
        raw[2] = v ? z : w;
        raw[1] = v ? z : x;
        raw[0] = (v & (x | z)) | (~v & y);
      end
    end else begin : g_weight
      digit_t sum;
      always_comb begin
        sum = (code_i[4] ? 4'd7 : 4'd0)
            + (code_i[3] ? 4'd4 : 4'd0)
            + (code_i[2] ? 4'd2 : 4'd0)
            + (code_i[1] ? 4'd1 : 4'd0);
        raw = (code_i == ZERO_CODE) ? 4'd0 : sum;
      end
    end
  endgenerate

  // Illegal words are forced to zero explicitly, never left to minimisation.
  assign digit_o = two_hot ? raw : '0;
endmodule

// File: rtl/zbd_bar_framer.sv
`timescale 1ns/1ps
module zbd_bar_framer #(
  parameter int DIGITS = 5,
  localparam int BPD    = zbd_pkg::CODE_W,
  localparam int BAR_W  = $clog2(BPD),
  localparam int SLOT_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bar_valid_i,
  input  logic              bar_in_i,
  output zbd_pkg::code_t    word_o,
  output logic              word_ready_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              frame_last_o
);
  logic [BAR_W-1:0]  bar_q,  bar_n;
  logic [SLOT_W-1:0] slot_q, slot_n;
  logic [BPD-2:0]    part_q, part_n;
  logic              last_bar, last_slot;

  assign last_bar  = (bar_q  == BAR_W'(BPD - 1));
  assign last_slot = (slot_q == SLOT_W'(DIGITS - 1));

  assign word_o       = {part_q, bar_in_i};
  assign word_ready_o = bar_valid_i & last_bar;
  assign frame_last_o = word_ready_o & last_slot;
  assign slot_o       = slot_q;

  // Next state: everything holds unless a bar is accepted.
  always_comb begin
    bar_n  = bar_q;
    slot_n = slot_q;
    part_n = part_q;
    if (bar_valid_i) begin
      part_n = {part_q[BPD-3:0], bar_in_i};
      if (last_bar) begin
        bar_n  = '0;
        slot_n = last_slot ? '0 : slot_q + SLOT_W'(1);
      end else begin
        bar_n  = bar_q + BAR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bar_q  <= '0;
      slot_q <= '0;
      part_q <= '0;
    end else if (bar_valid_i) begin
      bar_q  <= bar_n;
      slot_q <= slot_n;
      part_q <= part_n;
    end
  end
endmodule

// File: rtl/zbd_frame_store.sv
`timescale 1ns/1ps
module zbd_frame_store #(
  parameter int DIGITS = 5,
  localparam int DW     = zbd_pkg::DIGIT_W,
  localparam int SLOT_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_ready_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              frame_last_i,
  input  zbd_pkg::digit_t   digit_i,
  input  logic              bad_i,
  output logic [DIGITS*DW-1:0] digits_o,
  output logic              done_o,
  output logic              frame_error_o
);
  // Working store, indexed by slot (slot 0 is the first digit received).
  logic [DW-1:0] work_q [DIGITS];
  logic [DW-1:0] work_n [DIGITS];
  logic [DW-1:0] out_q  [DIGITS];
  logic [DW-1:0] out_n  [DIGITS];
  logic          err_acc_q, err_acc_n;
  logic          err_q, err_n;
  logic          done_q;

  always_comb begin
    for (int k = 0; k < DIGITS; k++) begin
      work_n[k] = work_q[k];
      if (word_ready_i && (slot_i == SLOT_W'(k))) work_n[k] = digit_i;
      out_n[k] = frame_last_i ? work_n[k] : out_q[k];
    end
    err_acc_n = err_acc_q;
    err_n     = err_q;
    if (frame_last_i) begin
      err_n     = err_acc_q | bad_i;
      err_acc_n = 1'b0;
    end else if (word_ready_i) begin
      err_acc_n = err_acc_q | bad_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DIGITS; k++) begin
        work_q[k] <= '0;
        out_q[k]  <= '0;
      end
      err_acc_q <= 1'b0;
      err_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= frame_last_i;
      if (word_ready_i) begin
        for (int k = 0; k < DIGITS; k++) begin
          work_q[k] <= work_n[k];
          out_q[k]  <= out_n[k];
        end
        err_acc_q <= err_acc_n;
        err_q     <= err_n;
      end
    end
  end

  // The first digit lands in the top nibble.
  for (genvar k = 0; k < DIGITS; k++) begin : g_pack
    assign digits_o[(DIGITS-1-k)*DW +: DW] = out_q[k];
  end

  assign done_o        = done_q;
  assign frame_error_o = err_q;
endmodule

// File: rtl/zip_bar_decoder.sv
`timescale 1ns/1ps
module zip_bar_decoder #(
  parameter int DIGITS = 5,
  parameter zbd_pkg::dec_style_e DEC_STYLE = zbd_pkg::DEC_SOP,
  localparam int DW     = zbd_pkg::DIGIT_W,
  localparam int SLOT_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bar_valid_i,
  input  logic                 bar_in_i,
  output logic [DIGITS*DW-1:0] digits_o,
  output logic                 done_o,
  output logic                 frame_error_o
);
  zbd_pkg::code_t  word;
  zbd_pkg::digit_t digit;
  logic            word_ready, frame_last, bad;
  logic [SLOT_W-1:0] slot;

  zbd_bar_framer #(.DIGITS(DIGITS)) framer_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bar_valid_i  (bar_valid_i),
    .bar_in_i     (bar_in_i),
    .word_o       (word),
    .word_ready_o (word_ready),
    .slot_o       (slot),
    .frame_last_o (frame_last)
  );

  zbd_word_decoder #(.DEC_STYLE(DEC_STYLE)) decoder_i (
    .code_i  (word),
    .digit_o (digit),
    .bad_o   (bad)
  );

  zbd_frame_store #(.DIGITS(DIGITS)) store_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .word_ready_i  (word_ready),
    .slot_i        (slot),
    .frame_last_i  (frame_last),
    .digit_i       (digit),
    .bad_i         (bad),
    .digits_o      (digits_o),
    .done_o        (done_o),
    .frame_error_o (frame_error_o)
  );
endmodule

// File: rtl/zbd_checker.sv
`timescale 1ns/1ps
module zbd_checker #(
  parameter int DIGITS = 5,
  localparam int DW   = zbd_pkg::DIGIT_W,
  localparam int BARS = DIGITS * zbd_pkg::CODE_W,
  localparam int CW   = $clog2(BARS + 2)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bar_valid_i,
  input logic [DIGITS*DW-1:0] digits_o,
  input logic                 done_o,
  input logic                 frame_error_o
);
  // Bars accepted since the last done pulse.
  logic [CW-1:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= (done_o ? '0 : seen_q) + CW'(bar_valid_i);
  end

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_frame_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (seen_q == CW'(BARS)));

  assert_no_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q <= CW'(BARS));

  assert_hold_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(digits_o) && $stable(frame_error_o)));

  assert_idle_no_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(bar_valid_i));

  for (genvar k = 0; k < DIGITS; k++) begin : g_rng
    assert_digit_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      digits_o[k*DW +: DW] <= 4'd9);
  end
endmodule

bind zip_bar_decoder zbd_checker #(.DIGITS(DIGITS)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .bar_valid_i   (bar_valid_i),
  .digits_o      (digits_o),
  .done_o        (done_o),
  .frame_error_o (frame_error_o)
);

// File: tb/zip_bar_decoder_tb_top.sv
`timescale 1ns/1ps
module zip_bar_decoder_tb_top;
  localparam int ND = 5;
  localparam int NB = ND * 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bar_valid = 1'b0;
  logic bar_in = 1'b0;
  logic [4*ND-1:0] digits;
  logic done, ferr;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  zip_bar_decoder #(.DIGITS(ND)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bar_valid_i   (bar_valid),
    .bar_in_i      (bar_in),
    .digits_o      (digits),
    .done_o        (done),
    .frame_error_o (ferr)
  );

  // {code (first bar at MSB), illegal, expected digit}
  localparam logic [9:0] VEC [32] = '{
    {5'b00000, 1'b1, 4'h0}, {5'b00001, 1'b1, 4'h0}, {5'b00010, 1'b1, 4'h0}, {5'b00011, 1'b0, 4'h1},
    {5'b00100, 1'b1, 4'h0}, {5'b00101, 1'b0, 4'h2}, {5'b00110, 1'b0, 4'h3}, {5'b00111, 1'b1, 4'h0},
    {5'b01000, 1'b1, 4'h0}, {5'b01001, 1'b0, 4'h4}, {5'b01010, 1'b0, 4'h5}, {5'b01011, 1'b1, 4'h0},
    {5'b01100, 1'b0, 4'h6}, {5'b01101, 1'b1, 4'h0}, {5'b01110, 1'b1, 4'h0}, {5'b01111, 1'b1, 4'h0},
    {5'b10000, 1'b1, 4'h0}, {5'b10001, 1'b0, 4'h7}, {5'b10010, 1'b0, 4'h8}, {5'b10011, 1'b1, 4'h0},
    {5'b10100, 1'b0, 4'h9}, {5'b10101, 1'b1, 4'h0}, {5'b10110, 1'b1, 4'h0}, {5'b10111, 1'b1, 4'h0},
    {5'b11000, 1'b0, 4'h0}, {5'b11001, 1'b1, 4'h0}, {5'b11010, 1'b1, 4'h0}, {5'b11011, 1'b1, 4'h0},
    {5'b11100, 1'b1, 4'h0}, {5'b11101, 1'b1, 4'h0}, {5'b11110, 1'b1, 4'h0}, {5'b11111, 1'b1, 4'h0}
  };

  function automatic logic [4:0] code_of(input logic [3:0] d);
    case (d)
      4'd0: return 5'b11000;  4'd1: return 5'b00011;
      4'd2: return 5'b00101;  4'd3: return 5'b00110;
      4'd4: return 5'b01001;  4'd5: return 5'b01010;
      4'd6: return 5'b01100;  4'd7: return 5'b10001;
      4'd8: return 5'b10010;  default: return 5'b10100;
    endcase
  endfunction

  function automatic logic [NB-1:0] bars_of(input logic [4*ND-1:0] num);
    logic [NB-1:0] f;
    for (int k = 0; k < ND; k++) f[k*5 +: 5] = code_of(num[k*4 +: 4]);
    return f;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bar(input logic b);
    @(negedge clk);
    bar_valid = 1'b1;
    bar_in    = b;
  endtask

  task automatic send_bars(input logic [NB-1:0] f, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) drive_bar(f[i]);
  endtask

  // Ends a frame: next falling edge is the done cycle.
  task automatic close_frame();
    @(negedge clk);
    bar_valid = 1'b0;
    bar_in    = 1'b0;
  endtask

  task automatic full_frame_check(input logic [NB-1:0] f, input logic [4*ND-1:0] exp_d,
                                  input logic exp_e, input string req);
    send_bars(f, NB-1, 0);
    close_frame();
    check({req, " digits"}, 32'(digits), 32'(exp_d));
    check({req, " error"},  32'(ferr),   32'(exp_e));
    check("R4 done high", 32'(done), 32'd1);
    @(negedge clk);
    check("R4 done one cycle", 32'(done), 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [NB-1:0]   f;
    logic [4*ND-1:0] ed;
    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8 reset digits", 32'(digits), 32'd0);
    check("R8 reset error",  32'(ferr),   32'd0);
    check("R8 reset done",   32'(done),   32'd0);
    rst_n = 1'b1;

    // Table walk over all 32 words, one word per frame, rotating position.
    for (int i = 0; i < 32; i++) begin
      int slot = i % ND;
      for (int k = 0; k < ND; k++) begin
        f[(ND-1-k)*5 +: 5]  = (k == slot) ? VEC[i][9:5] : 5'b10001;
        ed[(ND-1-k)*4 +: 4] = (k == slot) ? VEC[i][3:0] : 4'd7;
      end
      full_frame_check(f, ed, VEC[i][4], VEC[i][4] ? "R2" : "R1");
    end

    // R3: order of bars and digits
    full_frame_check(bars_of(20'h12345), 20'h12345, 1'b0, "R3 order 12345");
    full_frame_check(bars_of(20'h98067), 20'h98067, 1'b0, "R3 order 98067");

    // R5: outputs hold while idle
    repeat (5) begin
      @(negedge clk);
      bar_in = ~bar_in;
      check("R5 hold digits", 32'(digits), 32'h98067);
      check("R5 hold done",   32'(done),   32'd0);
    end
    bar_in = 1'b0;

    // R6: error from one frame, cleared by the next legal frame
    f = bars_of(20'h08067);
    f[NB-1 -: 5] = 5'b11111;
    full_frame_check(f, 20'h08067, 1'b1, "R6 error set");
    full_frame_check(bars_of(20'h11111), 20'h11111, 1'b0, "R6 error cleared");

    // R7: idle gap with toggling bar_in inside a frame
    f = bars_of(20'h54321);
    send_bars(f, NB-1, 13);
    repeat (6) begin
      @(negedge clk);
      bar_valid = 1'b0;
      bar_in    = 1'b1;
      check("R7 no done in gap", 32'(done),   32'd0);
      check("R7 digits held",    32'(digits), 32'h11111);
    end
    send_bars(f, 12, 0);
    close_frame();
    check("R7 gap frame digits", 32'(digits), 32'h54321);
    check("R7 gap frame done",   32'(done),   32'd1);

    // R9: back-to-back frames
    f = bars_of(20'h13579);
    send_bars(f, NB-1, 0);
    f = bars_of(20'h24680);
    @(negedge clk);
    check("R9 first frame done",   32'(done),   32'd1);
    check("R9 first frame digits", 32'(digits), 32'h13579);
    bar_valid = 1'b1;
    bar_in    = f[NB-1];
    send_bars(f, NB-2, 0);
    close_frame();
    check("R9 second frame digits", 32'(digits), 32'h24680);
    check("R9 second frame done",   32'(done),   32'd1);

    // R8: reset mid-frame after an error frame
    full_frame_check(bars_of(20'h00000) ^ {NB{1'b1}}, 20'h00000, 1'b1, "R2 all-ones");
    send_bars(bars_of(20'h77777), NB-1, 15);
    @(negedge clk);
    bar_valid = 1'b0;
    rst_n     = 1'b0;
    #1;
    check("R8 mid reset error",  32'(ferr),   32'd0);
    check("R8 mid reset done",   32'(done),   32'd0);
    check("R8 mid reset digits", 32'(digits), 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    full_frame_check(bars_of(20'h31415), 20'h31415, 1'b0, "R8 frame after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule